// File: doc/BRIEF.md
# BCD Real-Time Calendar Core

This block keeps wall-clock time and a calendar in packed BCD: seconds, minutes, hours, weekday, day of month, month and a two-digit year covering 2000 to 2099. An external one-second pulse advances the count. Carries run from seconds through to the year. The block knows the length of each month and the leap-year rule for that century. Hours count in 24-hour form, or in 12-hour form with a PM flag.

Software uses a small word-addressed register port. To load a new time it first raises a hold request. It waits for the hold status, which settles over two slow-clock strobes. It then writes the time and calendar words and clears the hold. A separate run enable gates all counting, and its status bit lags the enable by a few slow strobes. Reads return either the live words, a snapshot pair that is refreshed while no snapshot read is in progress, or the live seconds byte on its own. A reader can compare that byte with the snapshot to detect a tick that landed in the middle of its read.

Top module: `rtc_calendar_core`

## Requirements
- R1: Register addresses on `wr_addr`/`rd_addr` are: 0 control (bit0 run enable, bit1 24-hour mode, bit2 read-only enable status), 1 hold (bit0 request, bit1 read-only hold status), 2 time, 3 calendar, 4 time snapshot, 5 calendar snapshot, 6 live seconds in bits 7:0. Unused addresses read 0. After reset the control register reads 0x2, the hold register reads 0, time reads 0x000000 and calendar reads 0x00010100.
- R2: Time word layout is hours[23:16], minutes[15:8], seconds[7:0], all BCD. With counting allowed, a `tick_1hz` pulse advances seconds. 59 wraps to 00 with a carry into minutes, and 59 minutes carry into hours. In 24-hour mode 23:59:59 wraps to 00:00:00 and advances the date.
- R3: Calendar word layout is year[31:24], month[23:16], day of month[15:8] and weekday[3:0] (0 to 6). A date advance moves weekday 6 to 0 and otherwise adds one. The last day of a month rolls over to day 01 of the next month. April, June, September and November have 30 days, and the other months except February have 31.
- R4: February has 29 days when the BCD year is divisible by 4, and 28 otherwise. Month 12 rolls to 01 with a year increment, and year 99 rolls to 00.
- R5: From the cycle after the hold request bit is written to 1, ticks are ignored. Hold status rises on the second slow strobe after the request.
- R6: Writes to the time and calendar words take effect only while hold status reads 1. Writes at any other time are ignored.
- R7: Writing 0 to the hold register clears the request. Status falls two slow strobes later, and counting then resumes from the loaded values.
- R8: Ticks are ignored while the run enable bit is 0 or enable status is 0. Enable status follows the enable bit after EN_LAG slow strobes (default 3).
- R9: With control bit1 at 0 (12-hour mode) the hour byte holds BCD 01 to 12 in bits 4:0 and a PM flag in bit 5. 11 rolls to 12 and toggles the flag, and 12 rolls to 01. Only 11:59:59 PM advances the date.
- R10: The snapshot pair copies the live time and calendar on every cycle in which no read is addressed to a snapshot register. Consecutive snapshot reads therefore see one frozen pair. A live-seconds read shows the advanced value one cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second from the prescaler |
| slow_stb | input | 1 | One-cycle pulse per slow-clock period, paces the status handshakes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read qualifier; a snapshot read freezes the snapshot |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Combinational read data for `rd_addr` |

## Verification
Read data is combinational, so the bench drives an address just after a rising edge, queues the expected word and compares it at the following falling edge of the same cycle. A tick or write in cycle N shows in the live words read in cycle N+1. The snapshot lags the live words by one further cycle, and one extra cycle for each back-to-back snapshot read. Both status bits are only checked after a margin of whole slow-strobe periods: a 24-cycle wait for the hold status (two strobes at one per 8 cycles) and a 32-cycle wait for the enable status. Each status is also checked as still unchanged in the cycle directly after its write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int WORD_W = 32;
    localparam int REG_AW = 3;
    localparam int BYTE_W = 8;

    localparam logic [REG_AW-1:0] RA_CTRL  = 3'd0;
    localparam logic [REG_AW-1:0] RA_HOLD  = 3'd1;
    localparam logic [REG_AW-1:0] RA_TIME  = 3'd2;
    localparam logic [REG_AW-1:0] RA_CAL   = 3'd3;
    localparam logic [REG_AW-1:0] RA_TSNAP = 3'd4;
    localparam logic [REG_AW-1:0] RA_CSNAP = 3'd5;
    localparam logic [REG_AW-1:0] RA_LSEC  = 3'd6;

    typedef struct packed {
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } tod_t;

    typedef struct packed {
        logic [BYTE_W-1:0] year;
        logic [BYTE_W-1:0] month;
        logic [BYTE_W-1:0] mday;
        logic [3:0]        rsv;
        logic [3:0]        wday;
    } cal_t;

    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

endpackage

// File: rtl/rtc_lag_sync.sv
module rtc_lag_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                sh_d = sh_q;
                if (stb) sh_d = d;
            end
        end else begin : g_chain
            always_comb begin
                sh_d = sh_q;
                if (stb) sh_d = {sh_q[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rtc_date_step.sv
module rtc_date_step
    import rtc_cal_pkg::*;
(
    input  tod_t cur_tm,
    input  cal_t cur_cal,
    input  logic h24,
    output tod_t nxt_tm,
    output cal_t nxt_cal
);
    logic              sec_wrap, min_wrap, day_carry, leap, end_of_month;
    logic [4:0]        h12;
    logic [BYTE_W-1:0] yr_bin, mlen, h12_inc;

    always_comb begin
        yr_bin = ({4'd0, cur_cal.year[7:4]} << 3) + ({4'd0, cur_cal.year[7:4]} << 1)
               + {4'd0, cur_cal.year[3:0]};
        leap = (yr_bin[1:0] == 2'b00);
        case (cur_cal.month)
            8'h02:                      mlen = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
            default:                    mlen = 8'h31;
        endcase
        end_of_month = (cur_cal.mday == mlen);
    end

    always_comb begin
        nxt_tm    = cur_tm;
        nxt_cal   = cur_cal;
        day_carry = 1'b0;
        h12       = cur_tm.hour[4:0];
        h12_inc   = bcd_inc({3'd0, h12});
        sec_wrap  = (cur_tm.sec == 8'h59);
        min_wrap  = (cur_tm.min == 8'h59);

        nxt_tm.sec = sec_wrap ? 8'h00 : bcd_inc(cur_tm.sec);
        if (sec_wrap) begin
            nxt_tm.min = min_wrap ? 8'h00 : bcd_inc(cur_tm.min);
            if (min_wrap) begin
                if (h24) begin
                    if (cur_tm.hour == 8'h23) begin
                        nxt_tm.hour = 8'h00;
                        day_carry   = 1'b1;
                    end else begin
                        nxt_tm.hour = bcd_inc(cur_tm.hour);
                    end
                end else begin
                    if (h12 == 5'h11) begin
                        nxt_tm.hour = {2'b00, ~cur_tm.hour[5], 5'h12};
                        day_carry   = cur_tm.hour[5];
                    end else if (h12 == 5'h12) begin
                        nxt_tm.hour = {2'b00, cur_tm.hour[5], 5'h01};
                    end else begin
                        nxt_tm.hour = {2'b00, cur_tm.hour[5], h12_inc[4:0]};
                    end
                end
            end
        end

        if (day_carry) begin
            nxt_cal.wday = (cur_cal.wday == 4'd6) ? 4'd0 : cur_cal.wday + 4'd1;
            if (end_of_month) begin
                nxt_cal.mday = 8'h01;
                if (cur_cal.month == 8'h12) begin
                    nxt_cal.month = 8'h01;
                    nxt_cal.year  = (cur_cal.year == 8'h99) ? 8'h00 : bcd_inc(cur_cal.year);
                end else begin
                    nxt_cal.month = bcd_inc(cur_cal.month);
                end
            end else begin
                nxt_cal.mday = bcd_inc(cur_cal.mday);
            end
        end
    end
endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
    import rtc_cal_pkg::*;
#(
    parameter int HOLD_LAG = 2,
    parameter int EN_LAG   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              slow_stb,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    typedef struct packed {
        logic run_en;
        logic h24;
        logic hold_req;
        tod_t tm;
        cal_t cal;
        tod_t tsnap;
        cal_t csnap;
    } core_st_t;

    localparam cal_t CAL_RST = '{year: 8'h00, month: 8'h01, mday: 8'h01, rsv: 4'h0, wday: 4'h0};
    localparam core_st_t ST_RST = '{run_en: 1'b0, h24: 1'b1, hold_req: 1'b0,
                                    tm: '0, cal: CAL_RST, tsnap: '0, csnap: CAL_RST};

    core_st_t s_d, s_q;
    logic     hold_ack, en_stat, count_ok, snap_rd;
    tod_t     step_tm;
    cal_t     step_cal;

    logic     hold_req, run_en;
    tod_t     live_tm, snap_tm;
    cal_t     live_cal;

    rtc_lag_sync #(.STAGES(HOLD_LAG)) u_hold_sync (
        .clk(clk), .rst_n(rst_n), .stb(slow_stb), .d(s_q.hold_req), .q(hold_ack)
    );

    rtc_lag_sync #(.STAGES(EN_LAG)) u_en_sync (
        .clk(clk), .rst_n(rst_n), .stb(slow_stb), .d(s_q.run_en), .q(en_stat)
    );

    rtc_date_step u_step (
        .cur_tm(s_q.tm), .cur_cal(s_q.cal), .h24(s_q.h24),
        .nxt_tm(step_tm), .nxt_cal(step_cal)
    );

    always_comb begin
        s_d      = s_q;
        count_ok = tick_1hz && s_q.run_en && en_stat && !s_q.hold_req && !hold_ack;
        snap_rd  = rd_en && ((rd_addr == RA_TSNAP) || (rd_addr == RA_CSNAP));

        if (count_ok) begin
            s_d.tm  = step_tm;
            s_d.cal = step_cal;
        end

        if (wr_en) begin
            case (wr_addr)
                RA_CTRL: begin
                    s_d.run_en = wr_data[0];
                    s_d.h24    = wr_data[1];
                end
                RA_HOLD: s_d.hold_req = wr_data[0];
                RA_TIME: if (hold_ack) s_d.tm  = wr_data[23:0];
                RA_CAL:  if (hold_ack) s_d.cal = wr_data;
                default: ;
            endcase
        end

        if (!snap_rd) begin
            s_d.tsnap = s_q.tm;
            s_d.csnap = s_q.cal;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= ST_RST;
        else        s_q <= s_d;
    end

    always_comb begin
        case (rd_addr)
            RA_CTRL:  rd_data = {29'd0, en_stat, s_q.h24, s_q.run_en};
            RA_HOLD:  rd_data = {30'd0, hold_ack, s_q.hold_req};
            RA_TIME:  rd_data = {8'd0, s_q.tm};
            RA_CAL:   rd_data = s_q.cal;
            RA_TSNAP: rd_data = {8'd0, s_q.tsnap};
            RA_CSNAP: rd_data = s_q.csnap;
            RA_LSEC:  rd_data = {24'd0, s_q.tm.sec};
            default:  rd_data = '0;
        endcase
    end

    assign hold_req = s_q.hold_req;
    assign run_en   = s_q.run_en;
    assign live_tm  = s_q.tm;
    assign live_cal = s_q.cal;
    assign snap_tm  = s_q.tsnap;
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk
    import rtc_cal_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1hz,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic              rd_en,
    input logic [REG_AW-1:0] rd_addr,
    input logic              hold_req,
    input logic              hold_ack,
    input logic              run_en,
    input tod_t              live_tm,
    input cal_t              live_cal,
    input tod_t              snap_tm
);
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_req || hold_ack) && !wr_en |=> $stable(live_tm) && $stable(live_cal)); // R5

    AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_ack) |-> hold_req); // R5

    AST_LOAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == RA_TIME) && !hold_ack && !tick_1hz |=> $stable(live_tm)); // R6

    AST_DISABLED_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en && !wr_en |=> $stable(live_tm) && $stable(live_cal)); // R8

    AST_SNAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && (rd_addr == RA_TSNAP) |=> $stable(snap_tm)); // R10

    AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tm.sec[3:0] <= 4'd9) && (live_tm.sec <= 8'h59)); // R2
endmodule

bind rtc_calendar_core rtc_calendar_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_addr(wr_addr),
    .rd_en(rd_en), .rd_addr(rd_addr), .hold_req(hold_req), .hold_ack(hold_ack),
    .run_en(run_en), .live_tm(live_tm), .live_cal(live_cal), .snap_tm(snap_tm)
);

// File: tb/test_rtc_calendar_core.sv
`timescale 1ns/1ps
module test_rtc_calendar_core;
    import rtc_cal_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick_1hz = 1'b0;
    logic              slow_stb;
    logic              wr_en = 1'b0;
    logic [REG_AW-1:0] wr_addr = '0;
    logic [WORD_W-1:0] wr_data = '0;
    logic              rd_en = 1'b0;
    logic [REG_AW-1:0] rd_addr = '0;
    logic [WORD_W-1:0] rd_data;
    logic [2:0]        stb_cnt = 3'd0;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 1'b0;

    typedef struct {
        logic [WORD_W-1:0] exp;
        string             tag;
    } exp_item_t;
    exp_item_t sb_q[$];

    always #2 clk = ~clk;

    always @(posedge clk) stb_cnt <= stb_cnt + 3'd1;
    assign slow_stb = (stb_cnt == 3'd0);

    rtc_calendar_core i_rtc_calendar_core (
        .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .slow_stb(slow_stb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    // monitor: compare each queued expectation in the cycle its read is driven
    always @(negedge clk) begin
        if (rd_en && rst_n) begin
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL scoreboard: read with no expectation, got %h exp none", rd_data);
            end else begin
                exp_item_t it;
                it = sb_q.pop_front();
                total++;
                if (rd_data !== it.exp) begin
                    bad++;
                    $display("FAIL %s: got %h exp %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic step(input logic tk, input logic rd, input logic [REG_AW-1:0] ra,
                        input logic [WORD_W-1:0] ex, input string tag);
        @(posedge clk) #1;
        wr_en    = 1'b0;
        tick_1hz = tk;
        rd_en    = rd;
        rd_addr  = ra;
        if (rd) sb_q.push_back('{exp: ex, tag: tag});
    endtask

    task automatic rd(input logic [REG_AW-1:0] ra, input logic [WORD_W-1:0] ex, input string tag);
        step(1'b0, 1'b1, ra, ex, tag);
    endtask

    task automatic tick1();
        step(1'b1, 1'b0, RA_CTRL, '0, "");
    endtask

    task automatic wr(input logic [REG_AW-1:0] a, input logic [WORD_W-1:0] d);
        @(posedge clk) #1;
        tick_1hz = 1'b0;
        rd_en    = 1'b0;
        wr_en    = 1'b1;
        wr_addr  = a;
        wr_data  = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk) #1;
            wr_en = 1'b0; tick_1hz = 1'b0; rd_en = 1'b0;
        end
    endtask

    task automatic set_dt(input logic [WORD_W-1:0] t, input logic [WORD_W-1:0] c);
        wr(RA_HOLD, 32'h1);
        idle(24);
        wr(RA_TIME, t);
        wr(RA_CAL, c);
        wr(RA_HOLD, 32'h0);
        idle(24);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        rd(RA_CTRL,  32'h2,        "R1 ctrl reset");
        rd(RA_HOLD,  32'h0,        "R1 hold reset");
        rd(RA_TIME,  32'h0,        "R1 time reset");
        rd(RA_CAL,   32'h00010100, "R1 cal reset");
        rd(RA_TSNAP, 32'h0,        "R1 snap reset");
        rd(3'd7,     32'h0,        "R1 unused addr");

        tick1();
        rd(RA_TIME, 32'h0, "R8 tick ignored while disabled");

        wr(RA_CTRL, 32'h3);
        rd(RA_CTRL, 32'h3, "R8 enable status lags");
        idle(32);
        rd(RA_CTRL, 32'h7, "R8 enable status set");

        wr(RA_TIME, 32'h123456);
        rd(RA_TIME, 32'h0, "R6 write ignored without hold");

        tick1();
        rd(RA_TIME, 32'h000001, "R2 tick advances seconds");

        wr(RA_HOLD, 32'h1);
        tick1();
        rd(RA_TIME, 32'h000001, "R5 tick ignored under request");
        rd(RA_HOLD, 32'h1,      "R5 status not yet set");
        idle(24);
        rd(RA_HOLD, 32'h3,      "R5 status set");

        wr(RA_TIME, 32'h235959);
        wr(RA_CAL,  32'h99123106);
        rd(RA_TIME, 32'h235959,   "R6 time load under hold");
        rd(RA_CAL,  32'h99123106, "R6 cal load under hold");
        tick1();
        rd(RA_TIME, 32'h235959,   "R5 tick ignored under hold");

        wr(RA_HOLD, 32'h0);
        rd(RA_HOLD, 32'h2, "R7 status lags release");
        idle(24);
        rd(RA_HOLD, 32'h0, "R7 status cleared");

        tick1();
        rd(RA_TIME, 32'h000000,   "R2 midnight wrap");
        rd(RA_CAL,  32'h00010100, "R4 year and month wrap");
        rd(RA_LSEC, 32'h00,       "R10 live seconds");

        set_dt(32'h000009, 32'h00010100);
        tick1();
        rd(RA_TIME, 32'h000010, "R2 BCD digit carry");

        set_dt(32'h005959, 32'h00010100);
        tick1();
        rd(RA_TIME, 32'h010000, "R2 minute to hour carry");

        set_dt(32'h235959, 32'h24022803);
        tick1();
        rd(RA_CAL, 32'h24022904, "R4 leap Feb 28");

        set_dt(32'h235959, 32'h24022904);
        tick1();
        rd(RA_CAL, 32'h24030105, "R4 leap Feb 29 end");

        set_dt(32'h235959, 32'h23022802);
        tick1();
        rd(RA_CAL, 32'h23030103, "R4 common Feb 28 end");

        set_dt(32'h235959, 32'h21043001);
        tick1();
        rd(RA_CAL, 32'h21050102, "R3 30-day month end");

        set_dt(32'h235959, 32'h21053102);
        tick1();
        rd(RA_CAL, 32'h21060103, "R3 31-day month end");

        wr(RA_CTRL, 32'h1);
        set_dt(32'h115959, 32'h21010100);
        tick1();
        rd(RA_TIME, 32'h320000,   "R9 11 AM to 12 PM");
        rd(RA_CAL,  32'h21010100, "R9 noon keeps date");

        set_dt(32'h325959, 32'h21010100);
        tick1();
        rd(RA_TIME, 32'h210000, "R9 12 PM to 1 PM");

        set_dt(32'h315959, 32'h21010100);
        tick1();
        rd(RA_TIME, 32'h120000,   "R9 11 PM to 12 AM");
        rd(RA_CAL,  32'h21010201, "R9 midnight advances date");

        set_dt(32'h125959, 32'h21010100);
        tick1();
        rd(RA_TIME, 32'h010000, "R9 12 AM to 1 AM");

        wr(RA_CTRL, 32'h3);
        set_dt(32'h101010, 32'h21010100);
        idle(2);
        rd(RA_TSNAP, 32'h101010,   "R10 time snapshot");
        rd(RA_CSNAP, 32'h21010100, "R10 cal snapshot");
        step(1'b1, 1'b1, RA_TSNAP, 32'h101010, "R10 snapshot during tick");
        rd(RA_TSNAP, 32'h101010, "R10 snapshot frozen while read");
        rd(RA_LSEC,  32'h11,     "R10 live seconds ahead");
        rd(RA_TSNAP, 32'h101011, "R10 snapshot refreshed");

        wr(RA_CTRL, 32'h2);
        rd(RA_CTRL, 32'h6, "R8 status lags disable");
        tick1();
        rd(RA_TIME, 32'h101011, "R8 tick ignored after disable");
        idle(32);
        rd(RA_CTRL, 32'h2, "R8 status cleared");

        idle(2);
        if (sb_q.size() != 0) begin
            bad++;
            $display("FAIL scoreboard: got %0d pending exp 0", sb_q.size());
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule